// File: doc/BRIEF.md
# Two-Stage Timebase Watchdog

This block is a memory-mapped watchdog for a processor subsystem. A 32-bit timebase counter runs freely from reset. A separate interval counter of `INTERVAL_BITS` bits runs only while two enable keys are set. The two keys sit in different registers, so one stray write cannot start or stop the watchdog.

The interval counter takes 2^N cycles to wrap. The first wrap sets a first-stage flag and raises a level interrupt. If software has not serviced the block by the next wrap, the block pulses a system reset request and records a reset-cause flag.

Software services the block by writing a one to the first-stage flag. That write clears the flag and starts a fresh interval. A build option locks both keys on once the watchdog has run, so that software cannot stop it.

Top module: `wdt_timebase`

## Requirements
- R1: After reset, `irq` and `rstReq` are low, and reads of word 0 (byte address 0x0), word 1 (0x4) and the unused address 0xC return zero. Read data appears on `rdData` one cycle after `rdEn` is sampled.
- R2: Word 2 (0x8) returns a 32-bit counter that starts at zero on reset, increments on every clock whatever the keys are, and ignores writes. Two reads some cycles apart return different values.
- R3: The interval counter advances only while key 1 (word 0 bit 1) and key 2 (word 1 bit 0) are both set. With only one key set, no interrupt occurs however long the wait.
- R4: The first stage flag is word 0 bit 2 and drives `irq` as a level. It is set exactly 2^N clock edges after the edge that completes the enable.
- R5: If the first-stage flag is still set when the next wrap occurs, 2^N edges after it was set, `rstReq` pulses high for exactly one cycle. The reset-cause flag (word 0 bit 3) is then set and stays set.
- R6: Writing 1 to word 0 bit 2 clears the first-stage flag, and `irq` is low in the following cycle. Writing 1 to word 0 bit 3 clears the reset-cause flag. Writing 0 to either bit leaves it unchanged.
- R7: A service write (word 0 bit 2 = 1) restarts the interval. The next first-stage flag comes 2^N edges after the service write.
- R8: When a service write lands on the same edge as a wrap, the service wins. No flag is set and no reset pulse is issued, and the next wrap comes 2^N edges after the service.
- R9: Clearing either key stops the watchdog: no interrupt and no reset pulse occur. Setting the key again restarts the count from zero, and a full 2^N edges pass before the first-stage flag.
- R10: With `ENABLE_ONCE` = 1, once both keys have been set together, writes that clear either key are ignored. Writes that clear the status flags still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Byte address; bits 3:2 select the word |
| wrEn | input | 1 | Write strobe |
| wrData | input | 32 | Write data |
| rdEn | input | 1 | Read strobe |
| rdData | output | 32 | Registered read data |
| irq | output | 1 | First-stage interrupt level |
| rstReq | output | 1 | One-cycle system reset request |

## Verification
The key collision is a service write that lands on the very edge on which the interval counter wraps for the second time. At that edge the first-stage flag is already set, so a late service would otherwise turn into a reset. The bench times the service write to that exact edge, counting from the measured rise of `irq`. It then checks three things: `irq` is low, no reset pulse was seen, and word 0 reads back with both flags clear. The next interrupt must come a full interval after the service edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [1:0] CSR0_IDX = 2'd0;
  localparam logic [1:0] CSR1_IDX = 2'd1;
  localparam logic [1:0] TB_IDX   = 2'd2;

  localparam int KEY2_BIT  = 0;  // word 1
  localparam int KEY1_BIT  = 1;  // word 0
  localparam int STATE_BIT = 2;  // word 0, write one to clear / service
  localparam int RST_BIT   = 3;  // word 0, write one to clear

  typedef struct packed {
    logic run;      // both keys set
    logic service;  // clear first-stage flag, restart interval
    logic clrRst;   // clear reset-cause flag
  } ctrlStrobe_t;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter bit ENABLE_ONCE = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [1:0]  wordSel,
  input  logic [3:0]  wrBits,
  output ctrlStrobe_t strb,
  output logic        enKey1,
  output logic        enKey2,
  output logic        lockOn
);
  logic wrCsr0, wrCsr1;

  assign wrCsr0 = wrEn && (wordSel == CSR0_IDX);
  assign wrCsr1 = wrEn && (wordSel == CSR1_IDX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enKey1 <= 1'b0;
      enKey2 <= 1'b0;
    end else begin
      if (wrCsr0 && (wrBits[KEY1_BIT] || !lockOn)) enKey1 <= wrBits[KEY1_BIT];
      if (wrCsr1 && (wrBits[KEY2_BIT] || !lockOn)) enKey2 <= wrBits[KEY2_BIT];
    end
  end

  generate
    if (ENABLE_ONCE) begin : g_lock
      logic lockQ;
      always_ff @(posedge clk) begin
        if (!rstN) lockQ <= 1'b0;
        else if (enKey1 && enKey2) lockQ <= 1'b1;
      end
      assign lockOn = lockQ;
    end else begin : g_noLock
      assign lockOn = 1'b0;
    end
  endgenerate

  always_comb begin
    strb.run     = enKey1 && enKey2;
    strb.service = wrCsr0 && wrBits[STATE_BIT];
    strb.clrRst  = wrCsr0 && wrBits[RST_BIT];
  end
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int INTERVAL_BITS = 16,
  parameter int TB_W          = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrobe_t     strb,
  output logic [TB_W-1:0] timebase,
  output logic            stateFlag,
  output logic            rstFlag,
  output logic            rstReq
);
  localparam logic [INTERVAL_BITS-1:0] IV_LAST = '1;

  logic [INTERVAL_BITS-1:0] ivCnt;
  logic wrapEv, secondEv;

  assign wrapEv   = strb.run && (ivCnt == IV_LAST) && !strb.service;
  assign secondEv = wrapEv && stateFlag;

  always_ff @(posedge clk) begin
    if (!rstN) timebase <= '0;
    else       timebase <= timebase + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.service || !strb.run) ivCnt <= '0;
    else                                    ivCnt <= ivCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateFlag <= 1'b0;
      rstFlag   <= 1'b0;
      rstReq    <= 1'b0;
    end else begin
      rstReq <= secondEv;
      if (strb.service)  stateFlag <= 1'b0;
      else if (wrapEv)   stateFlag <= 1'b1;
      if (secondEv)         rstFlag <= 1'b1;
      else if (strb.clrRst) rstFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/wdt_timebase.sv
module wdt_timebase
  import wdt_pkg::*;
#(
  parameter int INTERVAL_BITS = 16,
  parameter bit ENABLE_ONCE   = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  addr,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  input  logic        rdEn,
  output logic [31:0] rdData,
  output logic        irq,
  output logic        rstReq
);
  localparam int TB_W = 32;

  ctrlStrobe_t     strb;
  logic [1:0]      wordSel;
  logic            enKey1, enKey2, lockOn;
  logic            stateFlag, rstFlag;
  logic [TB_W-1:0] timebase;
  logic            unusedBits;

  assign wordSel    = addr[3:2];
  assign unusedBits = ^{addr[1:0], wrData[31:4]};

  wdt_ctrl #(.ENABLE_ONCE(ENABLE_ONCE)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wordSel(wordSel),
    .wrBits(wrData[3:0]), .strb(strb), .enKey1(enKey1),
    .enKey2(enKey2), .lockOn(lockOn)
  );

  wdt_datapath #(.INTERVAL_BITS(INTERVAL_BITS), .TB_W(TB_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .timebase(timebase),
    .stateFlag(stateFlag), .rstFlag(rstFlag), .rstReq(rstReq)
  );

  assign irq = stateFlag;

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else if (rdEn) begin
      case (wordSel)
        CSR0_IDX: begin
          rdData            <= '0;
          rdData[KEY1_BIT]  <= enKey1;
          rdData[STATE_BIT] <= stateFlag;
          rdData[RST_BIT]   <= rstFlag;
        end
        CSR1_IDX: begin
          rdData           <= '0;
          rdData[KEY2_BIT] <= enKey2;
        end
        TB_IDX:   rdData <= timebase;
        default:  rdData <= '0;
      endcase
    end
  end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker (
  input logic        clk,
  input logic        rstN,
  input logic        irq,
  input logic        rstReq,
  input logic [31:0] timebase,
  input logic        run,
  input logic        service,
  input logic        lockOn,
  input logic        enKey1
);
  AST_TB_STEP: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> timebase == $past(timebase) + 32'd1); // R2
  AST_IRQ_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(run)); // R3
  AST_RSTREQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq); // R5
  AST_RSTREQ_AFTER_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> $past(irq)); // R5
  AST_SERVICE_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    service |=> !irq); // R6
  AST_LOCK_KEEPS_KEY: assert property (@(posedge clk) disable iff (!rstN)
    lockOn |=> enKey1); // R10
endmodule

bind wdt_timebase wdt_checker u_chk (
  .clk(clk), .rstN(rstN), .irq(irq), .rstReq(rstReq), .timebase(timebase),
  .run(strb.run), .service(strb.service), .lockOn(lockOn), .enKey1(enKey1)
);

// File: tb/test_wdt_timebase.sv
module test_wdt_timebase;
  localparam int IVB = 5;
  localparam int P   = 1 << IVB;

  logic        clk = 1'b0, rstN = 1'b0;
  logic [3:0]  addr = '0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData, rdDataL;
  logic        irq, rstReq, irqL, rstReqL;

  always #10 clk = ~clk;  // 50 MHz

  wdt_timebase #(.INTERVAL_BITS(IVB), .ENABLE_ONCE(1'b0)) i_wdt_timebase (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .irq(irq), .rstReq(rstReq));

  wdt_timebase #(.INTERVAL_BITS(IVB), .ENABLE_ONCE(1'b1)) i_wdt_timebaseLock (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdDataL), .irq(irqL), .rstReq(rstReqL));

  int compared = 0, mismatched = 0, rstCnt = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];
  logic [31:0] tbModel = '0;
  logic        rdFire = 1'b0;

  always @(posedge clk) if (rstN) tbModel <= tbModel + 1;
  always @(posedge clk) rdFire <= rdEn;
  always @(negedge clk) if (rstReq) rstCnt++;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (rdFire) begin
      if (expQ.size() == 0) check("scoreboard underflow", 32'd1, 32'd0);
      else check(tagQ.pop_front(), rdData, expQ.pop_front());
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag,
                    output logic [31:0] mainV, output logic [31:0] lockV);
    rdEn = 1'b1; addr = a;
    expQ.push_back(a == 4'h8 ? tbModel : exp);
    tagQ.push_back(tag);
    @(posedge clk); @(negedge clk);
    rdEn = 1'b0;
    mainV = rdData; lockV = rdDataL;
  endtask

  task automatic waitIrq(output int n);
    n = 0;
    do begin @(posedge clk); n++; @(negedge clk); end while (!irq && n < 4*P);
  endtask

  task automatic waitRst(output int n);
    n = 0;
    do begin @(posedge clk); n++; @(negedge clk); end while (!rstReq && n < 4*P);
  endtask

  initial begin
    #(20 * 200000);
    check("watchdog expired", 32'd1, 32'd0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [31:0] v, vl, t1;
    int n, cntSave;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1 reset state
    check("R1 irq", irq, 0); check("R1 rstReq", rstReq, 0);
    rd(4'h0, 32'h0, "R1 word0", v, vl);
    rd(4'h4, 32'h0, "R1 word1", v, vl);
    rd(4'hC, 32'h0, "R1 unused", v, vl);

    // R2 timebase
    rd(4'h8, 0, "R2 timebase a", t1, vl);
    repeat (5) @(posedge clk); @(negedge clk);
    rd(4'h8, 0, "R2 timebase b", v, vl);
    check("R2 differs", {31'b0, v != t1}, 32'd1);
    wr(4'h8, 32'hFFFF_0000);
    rd(4'h8, 0, "R2 write ignored", v, vl);

    // R3 one key only
    wr(4'h0, 32'h2);
    repeat (2*P) @(posedge clk); @(negedge clk);
    check("R3 key1 only irq", irq, 0);
    wr(4'h0, 32'h0); wr(4'h4, 32'h1);
    repeat (2*P) @(posedge clk); @(negedge clk);
    check("R3 key2 only irq", irq, 0);
    rd(4'h4, 32'h1, "R3 key2 readback", v, vl);
    wr(4'h4, 32'h0);

    // R4 first stage
    wr(4'h0, 32'h2); wr(4'h4, 32'h1);
    waitIrq(n);
    check("R4 edges to irq", n, P);
    rd(4'h0, 32'h6, "R4 word0 state", v, vl);

    // R5 second stage
    waitRst(n);
    check("R5 edges to rstReq", n + 1, P);  // rd above took one edge
    @(negedge clk);
    check("R5 pulse one cycle", rstReq, 0);
    rd(4'h0, 32'hE, "R5 reset flag set", v, vl);
    rd(4'h0, 32'hE, "R5 reset flag holds", v, vl);

    // R6 write-one-to-clear
    wr(4'h0, 32'h2);
    rd(4'h0, 32'hE, "R6 zero write no effect", v, vl);
    wr(4'h0, 32'hA);
    rd(4'h0, 32'h6, "R6 reset flag cleared", v, vl);
    wr(4'h0, 32'h6);
    check("R6 irq dropped", irq, 0);
    // R7 service restarts interval
    waitIrq(n);
    check("R7 edges after service", n, P);
    check("R5 single reset so far", rstCnt, 1);

    // R8 service on the second-wrap edge
    cntSave = rstCnt;
    repeat (P-1) @(posedge clk); @(negedge clk);
    wr(4'h0, 32'h6);
    check("R8 irq low after collision", irq, 0);
    rd(4'h0, 32'h2, "R8 flags clear", v, vl);
    check("R8 no reset pulse", rstCnt, cntSave);
    waitIrq(n);
    check("R8 next interval", n + 1, P);

    // R9 stop by clearing key 1; R10 lock keeps keys
    wr(4'h0, 32'h4);
    check("R9 irq cleared", irq, 0);
    check("R10 lock status clear", irqL, 0);
    rd(4'h0, 32'h0, "R9 key1 cleared", v, vl);
    check("R10 lock key1 kept", vl, 32'h2);
    repeat (2*P) @(posedge clk); @(negedge clk);
    check("R9 stopped irq", irq, 0);
    check("R9 stopped no reset", rstCnt, cntSave);
    wr(4'h4, 32'h0);
    rd(4'h4, 32'h0, "R9 key2 cleared", v, vl);
    check("R10 lock key2 kept", vl, 32'h1);
    wr(4'h4, 32'h1); wr(4'h0, 32'h2);
    waitIrq(n);
    check("R9 restart full interval", n, P);

    repeat (3) @(posedge clk); @(negedge clk);
    check("scoreboard drained", expQ.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule